// File: doc/BRIEF.md
# Bidirectional SPI Master with Dual-Source Baud Generator

This block is a byte-wide SPI master that sits on a small controller's register bus. It has five byte registers. Software uses them to pick the line mode, the serial clock source and rate, and the single select line, and to start transfers and collect their results. In normal mode the master sends a byte on its data-out line and takes in a byte on its data-in line at the same time, MSB first. In bidirectional mode one shared data pin carries traffic both ways. A register bit drives the pin or releases it, so received bits come back from the pad.

The serial clock comes from one fast system clock through enable pulses only; the block derives no clock of its own. One source is an oscillator tick input that reaches the divider directly. The other is an internal prescaled source that pulses every 3, 6 or 12 system cycles. A power-of-two divider follows the selected source. Removing the clock enable freezes a transfer in place. A source change made during a transfer waits until the transfer ends. Toggling the pin-function select between general-purpose and SPI use clears every register and aborts any transfer.

Register map, by bus address: 0 control (bit0 bidirectional mode, bit1 pin drive enable, bit2 select assert), 1 status, read-only (bit0 busy, bit1 complete), 2 data (a write gives the transmit byte, a read returns the received byte), 3 clock (bit0 source, 1 = prescaled source and 0 = oscillator tick, bit1 enable), 4 baud (bits 2:0 divider code n, bits 7:6 prescale code).

Top module: `spi_bidir_master`

## Requirements
- R1: After reset every register reads 0, sck_o is 0, cs_no is 1 and sdo_oe_o is 1.
- R2: In normal mode a transfer sends the written byte MSB first on sdo_o and samples sdi_i at each rising sck_o edge. After the eighth bit the data register reads back the eight sampled bits, MSB first.
- R3: A transfer takes 16 serial-clock edge steps. Busy stays high from the cycle after the data write for exactly 16 × S × 2^n system cycles. S is the number of system cycles per source tick, and the prescaler and divider restart at the data write.
- R4: Divider code n makes each edge step last 2^n source ticks, for all codes 0 to 7 (1 to 128).
- R5: With the prescaled source, prescale codes 0, 1 and 2 give one tick every 3, 6 and 12 system cycles. Code 3 behaves as code 2.
- R6: With the oscillator source, the prescale code has no effect, and each cycle with osc_tick_i high is one source tick.
- R7: In bidirectional mode, sdo_oe_o equals the drive-enable bit. With drive enable clear, bits are sampled from sdo_i. With it set, the pad echoes sdo_o, so the received byte equals the sent byte. In normal mode sdo_oe_o is 1.
- R8: A source-select write made while busy does not change the timing of the current transfer. It takes effect for the next transfer.
- R9: While the clock enable is clear during a transfer, sck_o and busy hold. After it is set again the transfer finishes with the correct data, lengthened by exactly the cycles it was disabled.
- R10: A data write with the clock enable clear starts nothing. A data write while busy does not alter the byte being sent or the transfer length.
- R11: A change of spi_sel_i returns all registers to 0 and ends any transfer on the following clock edge.
- R12: The complete bit is set when busy falls at the end of a transfer. It is cleared by the data write that starts the next one, and it is never set together with busy.
- R13: sck_o idles low whenever not busy; cs_no is the inverse of control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_sel_i | input | 1 | Pin function select; any change clears the block |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Register write strobe |
| rdata_o | output | 8 | Register read data for addr_i (combinational) |
| osc_tick_i | input | 1 | Oscillator source tick, synchronous to clk_i |
| sck_o | output | 1 | Serial clock, idle low |
| cs_no | output | 1 | Select line, active low |
| sdo_o | output | 1 | Serial data out / shared pin output value |
| sdo_oe_o | output | 1 | Output enable for the shared data pin |
| sdo_i | input | 1 | Shared data pin pad readback |
| sdi_i | input | 1 | Serial data in (normal mode) |

## Verification
Busy shows at the first sample after the edge that takes the data write. It falls exactly 16 × S × 2^n cycles later, so the bench stamps the cycle of the write and of the first idle sample and compares their difference with a function of the source, prescale and divider codes. Received data and the complete bit are read only after busy is seen low. Register clearing is checked at the first sample after the edge that sees spi_sel_i change. For suspension and late writes, the cycles between the two register writes are added to the expected length.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_DATA = 3'd2,
    A_CLK  = 3'd3,
    A_BAUD = 3'd4
  } reg_addr_e;

  // prescale code -> shift amount applied to the base divide (code 3 aliases 2)
  function automatic int unsigned pre_shift(input logic [1:0] code);
    return (code == 2'd3) ? 2 : int'(code);
  endfunction
endpackage

// File: rtl/spi_bm_baud.sv
module spi_bm_baud
  import spi_bm_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int PRE_BASE = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             src_i,
  input  logic [1:0]       pre_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             osc_tick_i,
  output logic             edge_tick_o
);
  localparam int PRE_MAX = PRE_BASE * 4;
  localparam int PCNT_W  = $clog2(PRE_MAX);
  localparam int DCNT_W  = (1 << DIV_W) - 1;

  logic [PCNT_W-1:0] pcnt_q, plim;
  logic [DCNT_W-1:0] dcnt_q, dlim;
  logic              pll_tick, src_tick;

  assign plim     = PCNT_W'((PRE_BASE << pre_shift(pre_i)) - 1);
  assign dlim     = DCNT_W'((1 << div_i) - 1);
  assign pll_tick = en_i && (pcnt_q == plim);
  assign src_tick = src_i ? pll_tick : (en_i && osc_tick_i);
  assign edge_tick_o = src_tick && (dcnt_q == dlim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (clr_i) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      if (en_i) pcnt_q <= (pcnt_q == plim) ? '0 : pcnt_q + 1'b1;
      if (src_tick) dcnt_q <= (dcnt_q == dlim) ? '0 : dcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_bm_shift.sv
module spi_bm_shift
  import spi_bm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic [BUS_W-1:0] tx_i,
  input  logic             tick_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [BUS_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(BUS_W);

  logic             busy_q, sck_q, done_q;
  logic [BUS_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= tx_i;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[BUS_W-2:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        tx_q  <= {tx_q[BUS_W-2:0], 1'b0};
        if (cnt_q == CNT_W'(BUS_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[BUS_W-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_bidir_master.sv
module spi_bidir_master
  import spi_bm_pkg::*;
#(
  parameter int DIV_W    = 3,
  parameter int PRE_BASE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              osc_tick_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              sdo_i,
  input  logic              sdi_i
);
  localparam int PAD_W = BUS_W - 2 - DIV_W;

  logic             bidir_q, drive_q, cs_q;
  logic             src_sel_q, en_q, act_src_q, sel_prev_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       pre_q;
  logic             sel_chg, wr_ok, start, edge_tick, miso;
  logic             busy_w, done_w;
  logic [BUS_W-1:0] rx_w;

  assign sel_chg = spi_sel_i ^ sel_prev_q;
  assign wr_ok   = we_i && !sel_chg;
  assign start   = wr_ok && (addr_i == A_DATA) && en_q && !busy_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_prev_q <= 1'b0;
      bidir_q    <= 1'b0;
      drive_q    <= 1'b0;
      cs_q       <= 1'b0;
      src_sel_q  <= 1'b0;
      en_q       <= 1'b0;
      act_src_q  <= 1'b0;
      div_q      <= '0;
      pre_q      <= '0;
    end else begin
      sel_prev_q <= spi_sel_i;
      if (sel_chg) begin
        bidir_q   <= 1'b0;
        drive_q   <= 1'b0;
        cs_q      <= 1'b0;
        src_sel_q <= 1'b0;
        en_q      <= 1'b0;
        act_src_q <= 1'b0;
        div_q     <= '0;
        pre_q     <= '0;
      end else begin
        // source swap only between transfers
        if (!busy_w) act_src_q <= src_sel_q;
        if (wr_ok) begin
          unique case (addr_i)
            A_CTRL: {cs_q, drive_q, bidir_q} <= wdata_i[2:0];
            A_CLK:  {en_q, src_sel_q} <= wdata_i[1:0];
            A_BAUD: begin
              pre_q <= wdata_i[BUS_W-1 -: 2];
              div_q <= wdata_i[DIV_W-1:0];
            end
            default: ;
          endcase
        end
      end
    end
  end

  spi_bm_baud #(.DIV_W(DIV_W), .PRE_BASE(PRE_BASE)) u_baud (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (sel_chg || start),
    .en_i        (en_q),
    .src_i       (act_src_q),
    .pre_i       (pre_q),
    .div_i       (div_q),
    .osc_tick_i  (osc_tick_i),
    .edge_tick_o (edge_tick)
  );

  assign miso = bidir_q ? sdo_i : sdi_i;

  spi_bm_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sel_chg),
    .start_i (start),
    .tx_i    (wdata_i),
    .tick_i  (edge_tick),
    .miso_i  (miso),
    .sck_o   (sck_o),
    .mosi_o  (sdo_o),
    .busy_o  (busy_w),
    .done_o  (done_w),
    .rx_o    (rx_w)
  );

  assign sdo_oe_o = !bidir_q || drive_q;
  assign cs_no    = !cs_q;

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {5'b0, cs_q, drive_q, bidir_q};
      A_STAT:  rdata_o = {6'b0, done_w, busy_w};
      A_DATA:  rdata_o = rx_w;
      A_CLK:   rdata_o = {6'b0, en_q, src_sel_q};
      A_BAUD:  rdata_o = {pre_q, PAD_W'(0), div_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_bidir_master_chk.sv
module spi_bidir_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic done_i,
  input logic sck_i,
  input logic en_i,
  input logic act_src_i,
  input logic sel_chg_i
);
  p_sck_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sck_i);

  p_suspend_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !en_i && !sel_chg_i) |=> $stable(sck_i));

  p_src_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(act_src_i));

  p_done_on_end_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !$past(sel_chg_i)) |-> done_i);

  p_busy_done_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && done_i));
endmodule

bind spi_bidir_master spi_bidir_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_w),
  .done_i    (done_w),
  .sck_i     (sck_o),
  .en_i      (en_q),
  .act_src_i (act_src_q),
  .sel_chg_i (sel_chg)
);

// File: tb/tb_spi_bidir_master.sv
module tb_spi_bidir_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       spi_sel_i = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic       osc_tick_i = 1'b1;
  logic       sck_o, cs_no, sdo_o, sdo_oe_o, sdo_i, sdi_i;

  int         n_chk = 0;
  int         n_fail = 0;
  int         cyc = 0;
  logic [7:0] slv_sh = '0;
  logic [7:0] mosi_cap = '0;
  logic       slave_bit;

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, DATA = 3'd2, CLK = 3'd3, BAUD = 3'd4;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  assign slave_bit = slv_sh[7];
  assign sdi_i     = slave_bit;
  assign sdo_i     = sdo_oe_o ? sdo_o : slave_bit;

  always @(negedge sck_o) slv_sh = {slv_sh[6:0], 1'b0};
  always @(posedge sck_o) mosi_cap = {mosi_cap[6:0], sdo_o};

  spi_bidir_master dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .spi_sel_i(spi_sel_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .osc_tick_i(osc_tick_i),
    .sck_o(sck_o), .cs_no(cs_no), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .sdo_i(sdo_i), .sdi_i(sdi_i)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 40000; i++) begin
      rd(STAT, s);
      if (!s[0]) return;
      @(negedge clk_i);
    end
    check("wait_idle timeout", 1, 0);
  endtask

  function automatic int exp_cycles(input bit src, input int pre, input int dv);
    int s;
    s = src ? (3 << ((pre == 3) ? 2 : pre)) : 1;
    return 16 * s * (1 << dv);
  endfunction

  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sl, input int expc,
                          input logic [7:0] exp_rx, input bit chk_mosi, input string tag);
    logic [7:0] s;
    int t0;
    slv_sh = sl;
    mosi_cap = '0;
    wr(DATA, tx);
    t0 = cyc;
    rd(STAT, s);
    check({tag, " R12 start busy/done"}, int'(s[1:0]), 1);
    wait_idle();
    check({tag, " R3 length"}, cyc - t0, expc);
    rd(DATA, s);
    check({tag, " R2 rx"}, int'(s), int'(exp_rx));
    if (chk_mosi) check({tag, " R2 mosi"}, int'(mosi_cap), int'(tx));
    rd(STAT, s);
    check({tag, " R12 end done"}, int'(s[1:0]), 2);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk_i);
      wd++;
    end
    check("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, t;
    int ta, tb, t0, seed;
    seed = int'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), s);
      check("R1 reg reset", int'(s), 0);
    end
    check("R1 sck", int'(sck_o), 0);
    check("R1 cs_n", int'(cs_no), 1);
    check("R1 oe", int'(sdo_oe_o), 1);

    // R13 select line
    wr(CTRL, 8'h04);
    check("R13 cs asserted", int'(cs_no), 0);
    check("R13 sck idle", int'(sck_o), 0);

    // R10 start blocked with clock enable clear
    wr(DATA, 8'h55);
    rd(STAT, s);
    check("R10 no start when disabled", int'(s[0]), 0);

    // R2 R3 R4 directed, oscillator, divide 1
    wr(CLK, 8'h02);
    wr(BAUD, 8'h00);
    run_xfer(8'hA5, 8'h3C, 16, 8'h3C, 1, "dir0");
    run_xfer(8'h01, 8'hFF, 16, 8'hFF, 1, "dir1");

    // R5 prescale codes with prescaled source, divider code 1
    wr(CLK, 8'h03);
    for (int p = 0; p < 4; p++) begin
      wr(BAUD, {2'(p), 3'b0, 3'd1});
      run_xfer(8'hC3, 8'h96, exp_cycles(1, p, 1), 8'h96, 1, $sformatf("R5 pre%0d", p));
    end

    // R6 prescale ignored for oscillator source
    wr(CLK, 8'h02);
    wr(BAUD, {2'd2, 3'b0, 3'd2});
    run_xfer(8'h5A, 8'h81, 64, 8'h81, 1, "R6 osc pre2");

    // R4 maximum divider
    wr(BAUD, 8'h07);
    run_xfer(8'hE7, 8'h18, 2048, 8'h18, 1, "R4 div128");

    // random normal-mode transfers
    for (int k = 0; k < 6; k++) begin
      bit src; int pre, dv; logic [7:0] tx, sl;
      src = 1'($urandom % 2); pre = int'($urandom % 4); dv = int'($urandom % 4);
      tx = 8'($urandom); sl = 8'($urandom);
      wr(CLK, {6'b0, 1'b1, src});
      wr(BAUD, {2'(pre), 3'b0, 3'(dv)});
      run_xfer(tx, sl, exp_cycles(src, pre, dv), sl, 1, "R2 rand");
    end

    // R7 bidirectional receive and echo
    wr(CLK, 8'h02);
    wr(BAUD, 8'h01);
    wr(CTRL, 8'h01);
    check("R7 oe released", int'(sdo_oe_o), 0);
    run_xfer(8'hF0, 8'h6D, 32, 8'h6D, 0, "R7 recv");
    wr(CTRL, 8'h03);
    check("R7 oe driven", int'(sdo_oe_o), 1);
    run_xfer(8'h9B, 8'h00, 32, 8'h9B, 1, "R7 echo");
    wr(CTRL, 8'h00);
    check("R7 oe normal", int'(sdo_oe_o), 1);

    // R8 source change held during transfer
    wr(CLK, 8'h02);
    wr(BAUD, 8'h02);
    slv_sh = 8'h42;
    wr(DATA, 8'h24);
    t0 = cyc;
    repeat (5) @(negedge clk_i);
    wr(CLK, 8'h03);
    wait_idle();
    check("R8 held source length", cyc - t0, 64);
    run_xfer(8'h11, 8'h22, exp_cycles(1, 0, 2), 8'h22, 1, "R8 new source");

    // R9 suspend and resume
    wr(CLK, 8'h02);
    wr(BAUD, 8'h03);
    slv_sh = 8'hB4;
    mosi_cap = '0;
    wr(DATA, 8'h4B);
    t0 = cyc;
    repeat (40) @(negedge clk_i);
    wr(CLK, 8'h00);
    ta = cyc;
    t = {7'b0, sck_o};
    repeat (50) @(negedge clk_i);
    rd(STAT, s);
    check("R9 busy held", int'(s[0]), 1);
    check("R9 sck held", int'(sck_o), int'(t[0]));
    wr(CLK, 8'h02);
    tb = cyc;
    wait_idle();
    check("R9 resumed length", cyc - t0, 128 + (tb - ta));
    rd(DATA, s);
    check("R9 rx", int'(s), 8'hB4);
    check("R9 mosi", int'(mosi_cap), 8'h4B);

    // R10 data write while busy ignored
    wr(BAUD, 8'h02);
    slv_sh = 8'h0F;
    mosi_cap = '0;
    wr(DATA, 8'h81);
    t0 = cyc;
    repeat (10) @(negedge clk_i);
    wr(DATA, 8'h7E);
    wait_idle();
    check("R10 busy write length", cyc - t0, 64);
    check("R10 busy write mosi", int'(mosi_cap), 8'h81);

    // R11 pin-function change clears all
    wr(CTRL, 8'h07);
    wr(BAUD, 8'hC5);
    wr(DATA, 8'h33);
    repeat (20) @(negedge clk_i);
    spi_sel_i = 1'b0;
    @(negedge clk_i);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), s);
      check($sformatf("R11 reg %0d cleared", a), int'(s), 0);
    end
    check("R11 sck low", int'(sck_o), 0);
    check("R11 cs released", int'(cs_no), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule